// File: doc/BRIEF.md
# Tiled Surface Stride Validator

This block decides whether a buffer object may be switched to a requested tiling layout on a chosen hardware generation. A request carries a generation number, a flag saying whether Y tiles are 128 bytes wide, the tiling mode, the row stride in bytes, the object size in bytes and the object's current aperture placement (offset and size). The block applies the per-generation pitch, size and shape rules and returns an accept flag.

The block also reports whether the current placement must be given up (a rebind) because it no longer meets the fence alignment rules of the new layout. Results are registered. They appear one cycle after the request strobe and are held until the next request.

Top module: `tile_stride_checker`

## Requirements
- R1: Mode 0 (linear) is always accepted with rebind 0, whatever the stride, size or placement. Mode encoding: 0 linear, 1 X tiled, 2 Y tiled, 3 reserved.
- R2: The tile width is 128 bytes when the generation is 2 or below, or when the mode is Y and the 128-byte-Y flag is set. Otherwise it is 512 bytes. A tiled stride below the tile width is rejected.
- R3: On generation 7 and later a tiled request is rejected when floor(stride/128) exceeds MAX_PITCH_G7 (default 2047). On generations 4 to 6 the limit is MAX_PITCH_G4 (default 1023).
- R4: On generation 3 and below a tiled stride above 8192 bytes is rejected.
- R5: On generation 3 a tiled object larger than MAX_SIZE_VAL·2^20 bytes is rejected. On generation 2 and below the limit is MAX_SIZE_VAL·2^19 (default MAX_SIZE_VAL 128).
- R6: On generation 4 and later the tiled stride must be a multiple of the tile width. On earlier generations it must be a power of two.
- R7: On generation 3 and below, an accepted tiled request sets rebind if any of these holds: the offset has bits outside the fence start mask (default 0x0FF00000 for generation 3, 0x07F80000 below); the placement size differs from the required size; the offset is not a multiple of the required size. The required size is the smallest power of two at least the object size, and no less than 1 MiB on generation 3 or 512 KiB below. A rejected request always gives rebind 0.
- R8: On generation 4 and later rebind is always 0.
- R9: rsp_valid is 1 exactly in the cycle after a cycle with req_valid high. After reset rsp_valid, accept and rebind are 0.
- R10: While req_valid is low, accept and rebind keep their values and input changes have no effect on them.
- R11: A tiled request with stride 0 is rejected.
- R12: A mode 3 request is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| gen_i | input | GEN_W | Hardware generation number |
| y128_i | input | 1 | Y tiles are 128 bytes wide |
| mode_i | input | 2 | Tiling mode (0 linear, 1 X, 2 Y, 3 reserved) |
| stride_i | input | STRIDE_W | Row stride in bytes |
| size_i | input | SIZE_W | Object size in bytes |
| place_off_i | input | SIZE_W | Current aperture offset |
| place_size_i | input | SIZE_W | Current aperture placement size |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| accept_o | output | 1 | Layout is legal |
| rebind_o | output | 1 | Placement must be released |

## Verification
The pitch and size legality decision and the placement decision are made in the same cycle, and rebind is meaningful only when accept is also set. The bench provokes this overlap with generation 2 and 3 requests that have a legal stride and size but a misaligned, outside-mask or wrongly sized placement. It also sends requests whose placement is bad but whose stride is illegal. Each response is judged on both flags together against the scoreboard entry, so a rebind reported for a rejected request, or one that is missing on an accepted request, is flagged.

// File: rtl/tsv_pkg.sv
package tsv_pkg;

  typedef enum logic [1:0] {
    TM_LINEAR = 2'd0,
    TM_X      = 2'd1,
    TM_Y      = 2'd2,
    TM_RSVD   = 2'd3
  } tile_mode_e;

  // generation thresholds that change the rule set
  localparam int GEN_NARROW_MAX = 2;  // at or below: narrow tiles, half size cap
  localparam int GEN_FENCE_END  = 4;  // from here: pitch units, free placement
  localparam int GEN_WIDE_PITCH = 7;  // from here: wide pitch limit

  localparam int NARROW_TILE_B = 128;
  localparam int WIDE_TILE_B   = 512;
  localparam int PITCH_UNIT_B  = 128;

endpackage

// File: rtl/tsv_tile_width.sv
module tsv_tile_width
  import tsv_pkg::*;
#(
  parameter int GEN_W    = 4,
  parameter int STRIDE_W = 32
) (
  input  logic [GEN_W-1:0]    gen_i,
  input  logic                y128_i,
  input  tile_mode_e          mode_i,
  output logic [STRIDE_W-1:0] tile_w_o
);

  logic narrow_gen;
  logic narrow_y;

  always_comb begin
    narrow_gen = (gen_i <= GEN_W'(GEN_NARROW_MAX));
    narrow_y   = (mode_i == TM_Y) && y128_i;
    if (narrow_gen || narrow_y) begin
      tile_w_o = STRIDE_W'(NARROW_TILE_B);
    end else begin
      tile_w_o = STRIDE_W'(WIDE_TILE_B);
    end
  end

endmodule

// File: rtl/tsv_pitch_rules.sv
module tsv_pitch_rules
  import tsv_pkg::*;
#(
  parameter int GEN_W          = 4,
  parameter int STRIDE_W       = 32,
  parameter int SIZE_W         = 32,
  parameter int MAX_PITCH_G4   = 1023,
  parameter int MAX_PITCH_G7   = 2047,
  parameter int OLD_STRIDE_CAP = 8192,
  parameter int MAX_SIZE_VAL   = 128
) (
  input  logic [GEN_W-1:0]    gen_i,
  input  tile_mode_e          mode_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [SIZE_W-1:0]   size_i,
  input  logic [STRIDE_W-1:0] tile_w_i,
  output logic                legal_o
);

  // a stride is over the pitch limit when stride >= (limit+1) * unit
  localparam longint unsigned G4_STRIDE_LIM =
    (longint'(MAX_PITCH_G4) + 64'd1) * longint'(PITCH_UNIT_B);
  localparam longint unsigned G7_STRIDE_LIM =
    (longint'(MAX_PITCH_G7) + 64'd1) * longint'(PITCH_UNIT_B);
  localparam longint unsigned OLD_STRIDE_LIM = longint'(OLD_STRIDE_CAP);
  localparam longint unsigned G3_SIZE_LIM    = longint'(MAX_SIZE_VAL) << 20;
  localparam longint unsigned G2_SIZE_LIM    = longint'(MAX_SIZE_VAL) << 19;

  logic [63:0] stride_x;
  logic [63:0] size_x;
  logic        is_fence_end;
  logic        is_wide_pitch;
  logic        is_gen3;
  logic        limit_ok;
  logic        width_ok;
  logic        shape_ok;

  always_comb begin
    stride_x      = 64'(stride_i);
    size_x        = 64'(size_i);
    is_fence_end  = (gen_i >= GEN_W'(GEN_FENCE_END));
    is_wide_pitch = (gen_i >= GEN_W'(GEN_WIDE_PITCH));
    is_gen3       = (gen_i == GEN_W'(3));

    if (is_wide_pitch) begin
      limit_ok = (stride_x < G7_STRIDE_LIM);
    end else if (is_fence_end) begin
      limit_ok = (stride_x < G4_STRIDE_LIM);
    end else if (is_gen3) begin
      limit_ok = (stride_x <= OLD_STRIDE_LIM) && (size_x <= G3_SIZE_LIM);
    end else begin
      limit_ok = (stride_x <= OLD_STRIDE_LIM) && (size_x <= G2_SIZE_LIM);
    end

    width_ok = (stride_i >= tile_w_i);

    if (is_fence_end) begin
      shape_ok = ((stride_i & (tile_w_i - STRIDE_W'(1))) == '0);
    end else begin
      shape_ok = (stride_i != '0) &&
                 ((stride_i & (stride_i - STRIDE_W'(1))) == '0);
    end

    unique case (mode_i)
      TM_LINEAR: legal_o = 1'b1;
      TM_X,
      TM_Y:      legal_o = limit_ok && width_ok && shape_ok;
      default:   legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tsv_place_rules.sv
module tsv_place_rules
  import tsv_pkg::*;
#(
  parameter int              GEN_W         = 4,
  parameter int              SIZE_W        = 32,
  parameter logic [SIZE_W-1:0] START_MASK_G3 = SIZE_W'(32'h0FF0_0000),
  parameter logic [SIZE_W-1:0] START_MASK_G2 = SIZE_W'(32'h07F8_0000)
) (
  input  logic [GEN_W-1:0]  gen_i,
  input  tile_mode_e        mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SIZE_W-1:0] place_off_i,
  input  logic [SIZE_W-1:0] place_size_i,
  output logic              keep_o
);

  localparam int XW = SIZE_W + 1;
  localparam logic [XW-1:0] MIN_G3 = XW'(1) << 20;
  localparam logic [XW-1:0] MIN_G2 = XW'(1) << 19;

  logic [SIZE_W-1:0] size_m1;
  logic [SIZE_W-1:0] smear;
  logic [XW-1:0]     pow2_up;
  logic [XW-1:0]     need;
  logic [SIZE_W-1:0] start_mask;
  logic              is_gen3;
  logic              free_place;
  logic              mask_ok;
  logic              size_ok;
  logic              align_ok;

  assign size_m1 = (size_i == '0) ? '0 : (size_i - SIZE_W'(1));

  // every bit at or below the highest set bit of size-1
  for (genvar i = 0; i < SIZE_W; i++) begin : g_smear
    assign smear[i] = |size_m1[SIZE_W-1:i];
  end

  always_comb begin
    is_gen3    = (gen_i == GEN_W'(3));
    free_place = (gen_i >= GEN_W'(GEN_FENCE_END)) || (mode_i == TM_LINEAR);
    pow2_up    = {1'b0, smear} + XW'(1);
    start_mask = is_gen3 ? START_MASK_G3 : START_MASK_G2;

    if (is_gen3) begin
      need = (pow2_up < MIN_G3) ? MIN_G3 : pow2_up;
    end else begin
      need = (pow2_up < MIN_G2) ? MIN_G2 : pow2_up;
    end

    mask_ok  = ((place_off_i & ~start_mask) == '0);
    size_ok  = ({1'b0, place_size_i} == need);
    align_ok = (({1'b0, place_off_i} & (need - XW'(1))) == '0);
    keep_o   = free_place || (mask_ok && size_ok && align_ok);
  end

endmodule

// File: rtl/tile_stride_checker.sv
module tile_stride_checker
  import tsv_pkg::*;
#(
  parameter int GEN_W          = 4,
  parameter int STRIDE_W       = 32,
  parameter int SIZE_W         = 32,
  parameter int MAX_PITCH_G4   = 1023,
  parameter int MAX_PITCH_G7   = 2047,
  parameter int OLD_STRIDE_CAP = 8192,
  parameter int MAX_SIZE_VAL   = 128,
  parameter logic [SIZE_W-1:0] START_MASK_G3 = SIZE_W'(32'h0FF0_0000),
  parameter logic [SIZE_W-1:0] START_MASK_G2 = SIZE_W'(32'h07F8_0000)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [GEN_W-1:0]    gen_i,
  input  logic                y128_i,
  input  logic [1:0]          mode_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [SIZE_W-1:0]   size_i,
  input  logic [SIZE_W-1:0]   place_off_i,
  input  logic [SIZE_W-1:0]   place_size_i,
  output logic                rsp_valid,
  output logic                accept_o,
  output logic                rebind_o
);

  tile_mode_e        mode;
  logic [STRIDE_W-1:0] tile_w;
  logic              legal;
  logic              keep;

  assign mode = tile_mode_e'(mode_i);

  tsv_tile_width #(
    .GEN_W   (GEN_W),
    .STRIDE_W(STRIDE_W)
  ) u_width (
    .gen_i   (gen_i),
    .y128_i  (y128_i),
    .mode_i  (mode),
    .tile_w_o(tile_w)
  );

  tsv_pitch_rules #(
    .GEN_W         (GEN_W),
    .STRIDE_W      (STRIDE_W),
    .SIZE_W        (SIZE_W),
    .MAX_PITCH_G4  (MAX_PITCH_G4),
    .MAX_PITCH_G7  (MAX_PITCH_G7),
    .OLD_STRIDE_CAP(OLD_STRIDE_CAP),
    .MAX_SIZE_VAL  (MAX_SIZE_VAL)
  ) u_pitch (
    .gen_i   (gen_i),
    .mode_i  (mode),
    .stride_i(stride_i),
    .size_i  (size_i),
    .tile_w_i(tile_w),
    .legal_o (legal)
  );

  tsv_place_rules #(
    .GEN_W        (GEN_W),
    .SIZE_W       (SIZE_W),
    .START_MASK_G3(START_MASK_G3),
    .START_MASK_G2(START_MASK_G2)
  ) u_place (
    .gen_i       (gen_i),
    .mode_i      (mode),
    .size_i      (size_i),
    .place_off_i (place_off_i),
    .place_size_i(place_size_i),
    .keep_o      (keep)
  );

  // next-state
  logic vld_d, acc_d, reb_d;
  logic acc_en;

  always_comb begin
    acc_en = req_valid;
    vld_d  = req_valid;
    acc_d  = accept_o;
    reb_d  = rebind_o;
    if (acc_en) begin
      acc_d = legal;
      reb_d = legal && !keep;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      accept_o  <= 1'b0;
      rebind_o  <= 1'b0;
    end else begin
      rsp_valid <= vld_d;
      accept_o  <= acc_d;
      rebind_o  <= reb_d;
    end
  end

  // R9: response strobe follows the request by one cycle
  a_r9_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R10: results held while idle
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(accept_o) && $stable(rebind_o)));
  // R1: linear always accepted, never rebinds
  a_r1_linear_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_i == 2'd0) |=> (accept_o && !rebind_o));
  // R8: newer generations keep placement
  a_r8_gen4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && gen_i >= GEN_W'(GEN_FENCE_END)) |=> !rebind_o);
  // R11: tiled stride of zero refused
  a_r11_zero_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_i != 2'd0 && stride_i == '0) |=> !accept_o);
  // R12: reserved mode refused
  a_r12_rsvd_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_i == 2'd3) |=> !accept_o);
  // R7: rebind only with accept
  a_r7_rebind_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rebind_o |-> accept_o);

endmodule

// File: tb/tile_stride_checker_tb_top.sv
`timescale 1ns/1ps
module tile_stride_checker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  gen_i;
  logic        y128_i;
  logic [1:0]  mode_i;
  logic [31:0] stride_i;
  logic [31:0] size_i;
  logic [31:0] place_off_i;
  logic [31:0] place_size_i;
  logic        rsp_valid;
  logic        accept_o;
  logic        rebind_o;

  always #2 clk = ~clk;  // 250 MHz

  tile_stride_checker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .gen_i(gen_i), .y128_i(y128_i), .mode_i(mode_i),
    .stride_i(stride_i), .size_i(size_i),
    .place_off_i(place_off_i), .place_size_i(place_size_i),
    .rsp_valid(rsp_valid), .accept_o(accept_o), .rebind_o(rebind_o)
  );

  typedef struct {
    logic  acc;
    logic  reb;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  localparam logic [31:0] MB = 32'h0010_0000;

  task automatic check(input string tag, input logic act_a, input logic exp_a,
                       input logic act_r, input logic exp_r);
    n_cmp++;
    if (act_a !== exp_a || act_r !== exp_r) begin
      n_bad++;
      $display("FAIL %s accept=%0b exp %0b rebind=%0b exp %0b",
               tag, act_a, exp_a, act_r, exp_r);
    end
  endtask

  // driver: one request per call, expectation pushed to scoreboard
  task automatic send(input string tag, input int gen, input bit cap,
                      input int mode, input logic [31:0] stride,
                      input logic [31:0] size, input logic [31:0] off,
                      input logic [31:0] psize, input logic ea, input logic er);
    exp_t e;
    @(negedge clk);
    req_valid    = 1'b1;
    gen_i        = 4'(gen);
    y128_i       = cap;
    mode_i       = 2'(mode);
    stride_i     = stride;
    size_i       = size;
    place_off_i  = off;
    place_size_i = psize;
    e.acc = ea; e.reb = er; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // idle with scrambled inputs; outputs must not move
  task automatic idle_hold(input string tag, input logic ea, input logic er);
    @(negedge clk);
    req_valid    = 1'b0;
    gen_i        = 4'd3;
    mode_i       = 2'd1;
    stride_i     = 32'd1536;
    size_i       = 32'd5;
    place_off_i  = 32'h1234;
    place_size_i = 32'd7;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({tag, " hold"}, accept_o, ea, rebind_o, er);
      n_cmp++;
      if (rsp_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL R9 rsp_valid=%0b exp 0 while idle", rsp_valid);
      end
    end
  endtask

  // monitor: compare each response against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 rsp_valid=1 exp 0 (no request pending)");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, accept_o, e.acc, rebind_o, e.reb);
      end
    end
  end

  task automatic finish_run();
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9 pending=%0d exp 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired=1 exp 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; gen_i = '0; y128_i = 1'b0; mode_i = '0;
    stride_i = '0; size_i = '0; place_off_i = '0; place_size_i = '0;
    repeat (3) @(negedge clk);
    check("R9 reset", accept_o, 1'b0, rebind_o, 1'b0);
    n_cmp++;
    if (rsp_valid !== 1'b0) begin
      n_bad++; $display("FAIL R9 reset rsp_valid=%0b exp 0", rsp_valid);
    end
    rst_n = 1'b1;

    // R1 linear, with otherwise illegal values and bad placement
    send("R1 linear gen2", 2, 0, 0, 32'd0, 32'hFFFF_FFFF, 32'h1, 32'd3, 1, 0);
    send("R1 linear gen3 bad place", 3, 0, 0, 32'd1536, MB, 32'h10000, MB, 1, 0);
    // R2 tile width
    send("R2 gen2 X 128", 2, 0, 1, 32'd128, MB, 0, MB, 1, 0);
    send("R2 gen3 X 256 narrow", 3, 0, 1, 32'd256, MB, 0, MB, 0, 0);
    send("R2 gen3 Y cap 128", 3, 1, 2, 32'd128, MB, 0, MB, 1, 0);
    send("R2 gen5 Y cap 384", 5, 1, 2, 32'd384, MB, 0, 0, 1, 0);
    send("R2 gen5 Y nocap 384", 5, 0, 2, 32'd384, MB, 0, 0, 0, 0);
    send("R2 gen5 X cap ignored 384", 5, 1, 1, 32'd384, MB, 0, 0, 0, 0);
    // R3 pitch limits
    send("R3 gen9 X 4096", 9, 0, 1, 32'd4096, MB, 0, 0, 1, 0);
    send("R3 gen5 X 130560", 5, 0, 1, 32'd130560, MB, 0, 0, 1, 0);
    send("R3 gen5 X 131072", 5, 0, 1, 32'd131072, MB, 0, 0, 0, 0);
    send("R3 gen7 X 131072", 7, 0, 1, 32'd131072, MB, 0, 0, 1, 0);
    send("R3 gen7 X 262144", 7, 0, 1, 32'd262144, MB, 0, 0, 0, 0);
    // R4 old stride cap
    send("R4 gen3 X 8192", 3, 0, 1, 32'd8192, MB, 0, MB, 1, 0);
    send("R4 gen3 X 16384", 3, 0, 1, 32'd16384, MB, 0, MB, 0, 0);
    // R5 size caps
    send("R5 gen3 128MB", 3, 0, 1, 32'd2048, 128*MB, 0, 128*MB, 1, 0);
    send("R5 gen3 128MB+1", 3, 0, 1, 32'd2048, 128*MB + 1, 0, 128*MB, 0, 0);
    send("R5 gen2 64MB", 2, 0, 1, 32'd2048, 64*MB, 0, 64*MB, 1, 0);
    send("R5 gen2 64MB+1", 2, 0, 1, 32'd2048, 64*MB + 1, 0, 128*MB, 0, 0);
    // R6 shape
    send("R6 gen9 X 640", 9, 0, 1, 32'd640, MB, 0, 0, 0, 0);
    send("R6 gen5 X 1536 multiple", 5, 0, 1, 32'd1536, MB, 0, 0, 1, 0);
    send("R6 gen3 X 1536 not pow2", 3, 0, 1, 32'd1536, MB, 0, MB, 0, 0);
    // R7 placement on older generations
    send("R7 gen3 aligned", 3, 0, 1, 32'd2048, 3*MB, 4*MB, 4*MB, 1, 0);
    send("R7 gen3 misaligned", 3, 0, 1, 32'd2048, 3*MB, 2*MB, 4*MB, 1, 1);
    send("R7 gen3 wrong size", 3, 0, 1, 32'd2048, 3*MB, 0, 2*MB, 1, 1);
    send("R7 gen3 outside mask", 3, 0, 1, 32'd2048, 3*MB, 32'h10000, 4*MB, 1, 1);
    send("R7 gen2 min 512K ok", 2, 0, 1, 32'd512, 32'd100000, 32'h80000, 32'h80000, 1, 0);
    send("R7 gen2 size too big", 2, 0, 2, 32'd512, 32'd100000, 32'h80000, MB, 1, 1);
    send("R7 rejected no rebind", 3, 0, 1, 32'd1536, 3*MB, 2*MB, 4*MB, 0, 0);
    // R8 newer generations keep placement
    send("R8 gen4 bad place", 4, 0, 1, 32'd1024, 3*MB, 32'h10000, 32'd7, 1, 0);
    // R11 and R12
    send("R11 gen9 X stride 0", 9, 0, 1, 32'd0, MB, 0, 0, 0, 0);
    send("R11 gen3 Y stride 0", 3, 1, 2, 32'd0, MB, 0, MB, 0, 0);
    send("R12 gen9 mode3", 9, 0, 3, 32'd4096, MB, 0, 0, 0, 0);
    // R10 hold after a rebinding result
    send("R10 setup", 3, 0, 1, 32'd2048, 3*MB, 2*MB, 4*MB, 1, 1);
    idle_hold("R10", 1, 1);
    send("R10 setup2", 9, 0, 1, 32'd640, MB, 0, 0, 0, 0);
    idle_hold("R10", 0, 0);

    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule